// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This block corrects an 8-bit accumulator after a binary addition or subtraction of two packed BCD operands, so that the accumulator again holds two valid decimal digits. It reads the accumulator and a flag byte. Only three of the input flags affect the result: the subtract marker, the half carry and the carry. It returns the corrected accumulator and a complete new flag byte.

The addition and subtraction corrections are computed in parallel by two separate datapaths. The subtract marker selects which one is used. A flag generator then builds sign, zero and parity from the final value. The result is registered and appears one clock after a valid input. Internal arithmetic is signed and wider than eight bits, so values above 0xFF and below zero are detected.

Flag byte layout, for input and output: bit 7 sign, bit 6 zero, bit 4 half carry, bit 2 parity, bit 1 subtract, bit 0 carry. Bits 3 and 5 are always zero on output.

Top module: `dadj_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge, and `acc_out`/`flags_out` show the result for that input. When `in_valid` is low, `out_valid` goes low. A synchronous active-high `rst` clears `out_valid`, `acc_out` and `flags_out` to zero.
- R2: Addition (input bit 1 clear), low digit: if the low nibble is 10 or more, add 6 and set output H (bit 4). If the low nibble is 9 or less, add 6 only when input H (bit 4) is set, and leave output H clear.
- R3: Addition, high digit: if the value after the low-digit step is 0xA0 or more, or input C (bit 0) is set, add 0x60 and set output C (bit 0). Otherwise output C is clear.
- R4: Subtraction (input bit 1 set), high digit first: if the accumulator is above 0x99 or input C is set, subtract 0x60 and set output C.
- R5: Subtraction, low digit second: if the low nibble is above 9 or input H is set, subtract 6. In that case output H is set only when the original low nibble is below 6. In all other cases output H is clear.
- R6: Subtraction: if the running value is negative after the low-digit subtraction and input H was clear, output C is set.
- R7: Output bit 1 equals input bit 1. Output bits 3 and 5 are zero. Input bits 7, 6, 5, 3 and 2 have no effect on any output.
- R8: Output S (bit 7) equals bit 7 of the result. Output Z (bit 6) is set when the result is zero. Output P (bit 2) is set when the result has an even number of one bits.
- R9: While `in_valid` is low, `acc_out` and `flags_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| acc_in | input | 8 | Accumulator before adjustment |
| flags_in | input | 8 | Flag byte before adjustment |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| acc_out | output | 8 | Adjusted accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
Each result, both the accumulator and the flag byte, is due exactly one rising edge after its input is presented. The bench drives every input on a falling edge, lets one rising edge pass, and samples on the following falling edge, so each vector is checked in exactly the cycle it is due. The sweep applies all 256 accumulator values under all eight subtract, half-carry and carry combinations. It also checks that a cycle without `in_valid` leaves the held result unchanged.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  localparam int ACC_W = 8;
  localparam int FLAG_W = 8;
  localparam int BIT_S = 7;
  localparam int BIT_Z = 6;
  localparam int BIT_H = 4;
  localparam int BIT_P = 2;
  localparam int BIT_N = 1;
  localparam int BIT_C = 0;

  typedef logic [ACC_W-1:0] acc_t;
  typedef logic [FLAG_W-1:0] flag_t;

  typedef struct packed {
    acc_t value;
    logic half;
    logic carry;
  } fix_t;
endpackage

// File: rtl/dadj_add_path.sv
module dadj_add_path
  import dadj_pkg::*;
#(
  parameter int CALC_W = 10
) (
  input  acc_t acc,
  input  logic h_in,
  input  logic c_in,
  output fix_t fix
);
  localparam logic signed [CALC_W-1:0] LOW_STEP  = CALC_W'(6);
  localparam logic signed [CALC_W-1:0] HIGH_STEP = CALC_W'(96);
  localparam logic signed [CALC_W-1:0] HIGH_LIM  = CALC_W'(160);

  logic signed [CALC_W-1:0] stage0, stage1, stage2;
  logic [3:0] low;
  logic half, carry;

  always_comb begin
    low    = acc[3:0];
    stage0 = $signed({{(CALC_W-ACC_W){1'b0}}, acc});
    half   = 1'b0;
    carry  = 1'b0;
    if (low >= 4'd10) begin
      half   = 1'b1;
      stage1 = stage0 + LOW_STEP;
    end else if (h_in) begin
      stage1 = stage0 + LOW_STEP;
    end else begin
      stage1 = stage0;
    end
    if (stage1 >= HIGH_LIM || c_in) begin
      carry  = 1'b1;
      stage2 = stage1 + HIGH_STEP;
    end else begin
      stage2 = stage1;
    end
    fix.value = stage2[ACC_W-1:0];
    fix.half  = half;
    fix.carry = carry;
  end
endmodule

// File: rtl/dadj_sub_path.sv
module dadj_sub_path
  import dadj_pkg::*;
#(
  parameter int CALC_W = 10
) (
  input  acc_t acc,
  input  logic h_in,
  input  logic c_in,
  output fix_t fix
);
  localparam logic signed [CALC_W-1:0] LOW_STEP  = CALC_W'(6);
  localparam logic signed [CALC_W-1:0] HIGH_STEP = CALC_W'(96);
  localparam logic signed [CALC_W-1:0] HIGH_LIM  = CALC_W'(153);

  logic signed [CALC_W-1:0] stage0, stage1, stage2;
  logic [3:0] low;
  logic half, carry;

  always_comb begin
    low    = acc[3:0];
    stage0 = $signed({{(CALC_W-ACC_W){1'b0}}, acc});
    half   = 1'b0;
    carry  = 1'b0;
    if (stage0 > HIGH_LIM || c_in) begin
      carry  = 1'b1;
      stage1 = stage0 - HIGH_STEP;
    end else begin
      stage1 = stage0;
    end
    if (low > 4'd9 || h_in) begin
      if (low < 4'd6) half = 1'b1;
      stage2 = stage1 - LOW_STEP;
      if (stage2 < 0 && !h_in) carry = 1'b1;
    end else begin
      stage2 = stage1;
    end
    fix.value = stage2[ACC_W-1:0];
    fix.half  = half;
    fix.carry = carry;
  end
endmodule

// File: rtl/dadj_flag_gen.sv
module dadj_flag_gen
  import dadj_pkg::*;
(
  input  fix_t  fix,
  input  logic  n_in,
  output flag_t flags
);
  logic [ACC_W:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < ACC_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ fix.value[i];
  end

  always_comb begin
    flags        = '0;
    flags[BIT_S] = fix.value[ACC_W-1];
    flags[BIT_Z] = (fix.value == '0);
    flags[BIT_H] = fix.half;
    flags[BIT_P] = par_chain[ACC_W];
    flags[BIT_N] = n_in;
    flags[BIT_C] = fix.carry;
  end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int CALC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic [7:0] flags_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic [7:0] flags_out
);
  fix_t add_fix, sub_fix, sel_fix;
  flag_t new_flags;
  logic n_in, h_in, c_in;

  assign n_in = flags_in[BIT_N];
  assign h_in = flags_in[BIT_H];
  assign c_in = flags_in[BIT_C];

  dadj_add_path #(.CALC_W(CALC_W)) u_add (
    .acc(acc_in), .h_in(h_in), .c_in(c_in), .fix(add_fix)
  );

  dadj_sub_path #(.CALC_W(CALC_W)) u_sub (
    .acc(acc_in), .h_in(h_in), .c_in(c_in), .fix(sub_fix)
  );

  assign sel_fix = n_in ? sub_fix : add_fix;

  dadj_flag_gen u_flags (
    .fix(sel_fix), .n_in(n_in), .flags(new_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out   <= sel_fix.value;
        flags_out <= new_flags;
      end
    end
  end
endmodule

// File: rtl/dadj_unit_checker.sv
module dadj_unit_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] flags_in,
  input logic       out_valid,
  input logic [7:0] acc_out,
  input logic [7:0] flags_out
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drops_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flags_in[1] && flags_in[0]) |=> flags_out[0]);
  p_sub_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flags_in[1] && flags_in[0]) |=> flags_out[0]);
  p_n_copy_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flags_out[1] == $past(flags_in[1])));
  p_zero_bits_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[3] == 1'b0 && flags_out[5] == 1'b0));
  p_sign_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[7] == acc_out[7]));
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[6] == (acc_out == 8'h00)));
  p_parity_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[2] == ~(^acc_out)));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_out) && $stable(flags_out)));
endmodule

bind dadj_unit dadj_unit_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .flags_in(flags_in),
  .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
);

// File: tb/dadj_unit_test.sv
module dadj_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] acc_in = '0;
  logic [7:0] flags_in = '0;
  logic out_valid;
  logic [7:0] acc_out, flags_out;

  int applied = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dadj_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
    .flags_in(flags_in), .out_valid(out_valid), .acc_out(acc_out),
    .flags_out(flags_out)
  );

  task automatic model(input int a, input bit n, input bit h, input bit c,
                       output logic [7:0] ra, output logic [7:0] rf);
    int v;
    int lo;
    bit oh, oc;
    int ones;
    v = a; lo = a % 16; oh = 0; oc = 0;
    if (!n) begin
      if (lo >= 10) begin oh = 1; v = v + 6; end
      else if (h) v = v + 6;
      if (v >= 160 || c) begin oc = 1; v = v + 96; end
    end else begin
      if (v > 153 || c) begin v = v - 96; oc = 1; end
      if (lo > 9 || h) begin
        if (lo < 6) oh = 1;
        v = v - 6;
        if (v < 0 && !h) oc = 1;
      end
    end
    ra = 8'(v);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += ra[i];
    rf = {ra[7], ra == 8'h00, 1'b0, oh, 1'b0, (ones % 2) == 0, n, oc};
  endtask

  task automatic check(input string req, input logic [7:0] got_a,
                       input logic [7:0] exp_a, input logic [7:0] got_f,
                       input logic [7:0] exp_f, input logic got_v, input logic exp_v);
    applied++;
    if (got_a !== exp_a || got_f !== exp_f || got_v !== exp_v) begin
      bad++;
      $display("FAIL %s: acc=%02h flags=%02h valid=%b expected acc=%02h flags=%02h valid=%b",
               req, got_a, got_f, got_v, exp_a, exp_f, exp_v);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    acc_in = a; flags_in = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] ea, ef, ha, hf;
    repeat (2) @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", acc_out, 8'h00, flags_out, 8'h00, out_valid, 1'b0);
    rst = 1'b0;

    // R2 R3 corner: 0x9A after addition gives 0x00 with H, C, Z, P
    apply(8'h9A, 8'h00);
    check("R2 R3 R8 9A", acc_out, 8'h00, flags_out, 8'h55, out_valid, 1'b1);
    // R4 R5 corner: 0x0A after subtraction with carry in
    apply(8'h0A, 8'h03);
    model(8'h0A, 1, 0, 1, ea, ef);
    check("R4 R5 R6 0A", acc_out, ea, flags_out, ef, out_valid, 1'b1);

    // R7: unused input bits ignored
    apply(8'h47, 8'hEC);
    model(8'h47, 0, 0, 0, ea, ef);
    check("R7 ignored bits", acc_out, ea, flags_out, ef, out_valid, 1'b1);

    // R9: hold while in_valid low, with changed inputs
    ha = acc_out; hf = flags_out;
    acc_in = 8'h99; flags_in = 8'h13;
    @(negedge clk);
    check("R9 hold", acc_out, ha, flags_out, hf, out_valid, 1'b0);

    // exhaustive sweep: R2 R3 (add) R4 R5 R6 (sub) R7 R8
    for (int sel = 0; sel < 8; sel++) begin
      for (int a = 0; a < 256; a++) begin
        bit n, h, c;
        n = sel[2]; h = sel[1]; c = sel[0];
        model(a, n, h, c, ea, ef);
        @(negedge clk);
        acc_in = 8'(a); flags_in = {3'b000, h, 2'b00, n, c}; in_valid = 1'b1;
        @(negedge clk);
        check(n ? "R4 R5 R6 R7 R8 sweep" : "R2 R3 R7 R8 sweep",
              acc_out, ea, flags_out, ef, out_valid, 1'b1);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid drop", acc_out, acc_out, flags_out, flags_out, out_valid, 1'b0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        applied++; bad++;
        $display("FAIL watchdog: expired, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule